// File: doc/BRIEF.md
# Filtered Interrupt Aggregator

This block merges a set of active-low interrupt request lines, one per downstream channel, into a single request toward a bus master. Every request line is first brought into the local clock domain through two flip-flops. It then passes through a level qualifier that accepts a change only after the new level has held for a set number of clock cycles. A falling level must hold longer before it is accepted than a rising level. The merged request drives the enable of an open-drain pull-down. The enable is high while at least one qualified line is low, and it drops only once every qualified line is back high.

Nothing is latched. A channel's request disappears as soon as its line has been high for long enough, and the block has no notion of which channel is currently routed. For reads, the neighbouring register logic pulses a capture strobe when a read begins. On that edge the block copies the qualified line states into a status vector, inverted so that 1 means an interrupt is pending. Bit i of the status vector belongs to channel i, and the surrounding register places it at bit 4+i.

Top module: `irqf_aggregate`

## Requirements
- R1: `irq_pull_low` is 1 while any channel's qualified level is low, and is 0 only when all qualified levels are high; each channel contributes the same way whatever else happens on the bus.
- R2: No request is held: once a channel's line returns high and stays high for at least `HIGH_REJ_CYC` cycles, that channel stops holding `irq_pull_low` and reads 0 at the next capture.
- R3: A low pulse on a raw line that lasts fewer than `LOW_REJ_CYC` clock cycles has no effect on either output; a low level held for `LOW_REJ_CYC` cycles or more is accepted.
- R4: While a channel is qualified low, a high pulse that lasts fewer than `HIGH_REJ_CYC` cycles is ignored; `irq_pull_low` stays 1 throughout.
- R5: When a raw line falls and stays low on an otherwise idle block, `irq_pull_low` rises at rising edge number `LOW_REJ_CYC`+3, counting the first edge after the change as edge 1. The release of the last low line drops `irq_pull_low` at edge `HIGH_REJ_CYC`+3 in the same way.
- R6: On a rising edge where `snap_req` is 1, `irq_status[i]` takes 1 if channel i is qualified low and 0 if it is qualified high. On all other edges `irq_status` keeps its value.
- R7: While `rst_n` is low, and right after it is released, `irq_pull_low` is 0 and `irq_status` is all zeros; qualified levels restart as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_irq_n | input | NUM_CH (4) | Raw active-low interrupt lines, bit i = channel i, asynchronous |
| snap_req | input | 1 | Capture strobe from the register logic at the start of a read |
| irq_pull_low | output | 1 | Enable for the open-drain pull-down of the merged interrupt; 1 = pull low |
| irq_status | output | NUM_CH (4) | Captured pending bits, 1 = channel interrupt; bit i lands at register bit 4+i |

## Verification
A qualifier counter that restarts at the wrong moment, or that uses the wrong threshold for a direction, shows up as `irq_pull_low` moving one or more edges early or late against the edge number fixed by R5. Such a counter can also let a pulse just under the limit reach the output within `LOW_REJ_CYC`+3 edges. A qualified level stuck low shows at the pull-down enable within one cycle, and at `irq_status` only on the next capture. The status register therefore has to be checked both on capture edges and across long stretches without a capture. A behavioural model is compared against both outputs on every clock, and directed cases land exactly on the threshold and one cycle below it.

// File: rtl/irqf_pkg.sv
`timescale 1ns/1ps
package irqf_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } irq_lvl_e;

    function automatic int unsigned irqf_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irqf_sync.sv
`timescale 1ns/1ps
module irqf_sync #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_n,
    output logic [NUM_CH-1:0] sync_n
);

    typedef struct packed {
        logic meta;
        logic stab;
    } sync_st_t;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        sync_st_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.meta = raw_n[g];
            st_d.stab = st_q.meta;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '{meta: 1'b1, stab: 1'b1};
            end else begin
                st_q <= st_d;
            end
        end

        assign sync_n[g] = st_q.stab;
    end

endmodule

// File: rtl/irqf_glitch_filter.sv
`timescale 1ns/1ps
module irqf_glitch_filter
    import irqf_pkg::*;
#(
    parameter int unsigned LOW_REJ_CYC  = 200,
    parameter int unsigned HIGH_REJ_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic lvl_out
);

    localparam int unsigned MAX_CYC = irqf_max(LOW_REJ_CYC, HIGH_REJ_CYC);
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(LOW_REJ_CYC - 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(HIGH_REJ_CYC - 1);

    typedef struct packed {
        irq_lvl_e      lvl;
        logic [CW-1:0] run;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        last_cnt = (st_q.lvl == LVL_HIGH) ? FALL_LAST : RISE_LAST;
        if (sync_in == st_q.lvl) begin
            st_d.run = '0;
        end else if (st_q.run == last_cnt) begin
            st_d.lvl = irq_lvl_e'(sync_in);
            st_d.run = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: LVL_HIGH, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_out = st_q.lvl;

endmodule

// File: rtl/irqf_merge.sv
`timescale 1ns/1ps
module irqf_merge #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] filt_lvl,
    input  logic              snap_req,
    output logic              pull_low,
    output logic [NUM_CH-1:0] status
);

    typedef struct packed {
        logic              pull;
        logic [NUM_CH-1:0] stat;
    } mrg_st_t;

    mrg_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pull = ~(&filt_lvl);
        if (snap_req) begin
            st_d.stat = ~filt_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pull: 1'b0, stat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_low = st_q.pull;
    assign status   = st_q.stat;

endmodule

// File: rtl/irqf_aggregate.sv
`timescale 1ns/1ps
module irqf_aggregate #(
    parameter int unsigned NUM_CH       = 4,
    parameter int unsigned LOW_REJ_CYC  = 200,
    parameter int unsigned HIGH_REJ_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_irq_n,
    input  logic              snap_req,
    output logic              irq_pull_low,
    output logic [NUM_CH-1:0] irq_status
);

    logic [NUM_CH-1:0] sync_lvl;
    logic [NUM_CH-1:0] filt_lvl;

    irqf_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (chan_irq_n),
        .sync_n (sync_lvl)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flt
        irqf_glitch_filter #(
            .LOW_REJ_CYC  (LOW_REJ_CYC),
            .HIGH_REJ_CYC (HIGH_REJ_CYC)
        ) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_lvl[g]),
            .lvl_out (filt_lvl[g])
        );
    end

    irqf_merge #(.NUM_CH(NUM_CH)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt_lvl (filt_lvl),
        .snap_req (snap_req),
        .pull_low (irq_pull_low),
        .status   (irq_status)
    );

endmodule

// File: rtl/irqf_checker.sv
`timescale 1ns/1ps
module irqf_checker
    import irqf_pkg::*;
#(
    parameter int unsigned NUM_CH       = 4,
    parameter int unsigned LOW_REJ_CYC  = 200,
    parameter int unsigned HIGH_REJ_CYC = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] sync_lvl,
    input logic [NUM_CH-1:0] filt_lvl,
    input logic              snap_req,
    input logic              irq_pull_low,
    input logic [NUM_CH-1:0] irq_status
);

    localparam int unsigned MAX_CYC = irqf_max(LOW_REJ_CYC, HIGH_REJ_CYC);
    localparam int unsigned RW      = $clog2(MAX_CYC + 2);
    localparam logic [RW-1:0] RUN_SAT = RW'(MAX_CYC + 1);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_run
        logic [RW-1:0] low_run_q, high_run_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                low_run_q  <= '0;
                high_run_q <= '0;
            end else begin
                low_run_q  <= sync_lvl[g] ? '0 :
                              ((low_run_q == RUN_SAT) ? low_run_q : low_run_q + 1'b1);
                high_run_q <= !sync_lvl[g] ? '0 :
                              ((high_run_q == RUN_SAT) ? high_run_q : high_run_q + 1'b1);
            end
        end

        // R3: a qualified fall needs LOW_REJ_CYC low samples in a row
        assert_low_qualify_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(filt_lvl[g]) |-> (low_run_q >= RW'(LOW_REJ_CYC)));

        // R4: a qualified rise needs HIGH_REJ_CYC high samples in a row
        assert_high_qualify_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(filt_lvl[g]) |-> (high_run_q >= RW'(HIGH_REJ_CYC)));
    end

    assert_raise_any_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull_low) |-> !$past(&filt_lvl));

    assert_release_all_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pull_low) |-> $past(&filt_lvl));

    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(irq_status));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_pull_low && (irq_status == '0)));

endmodule

bind irqf_aggregate irqf_checker #(
    .NUM_CH       (NUM_CH),
    .LOW_REJ_CYC  (LOW_REJ_CYC),
    .HIGH_REJ_CYC (HIGH_REJ_CYC)
) u_irqf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_lvl     (sync_lvl),
    .filt_lvl     (filt_lvl),
    .snap_req     (snap_req),
    .irq_pull_low (irq_pull_low),
    .irq_status   (irq_status)
);

// File: tb/test_irqf_aggregate.sv
`timescale 1ns/1ps
module test_irqf_aggregate;

    localparam int NCH  = 4;
    localparam int LREJ = 10;
    localparam int HREJ = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] raw = '1;
    logic           snap = 1'b0;
    logic           pull;
    logic [NCH-1:0] stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irqf_aggregate #(
        .NUM_CH       (NCH),
        .LOW_REJ_CYC  (LREJ),
        .HIGH_REJ_CYC (HREJ)
    ) i_irqf_aggregate (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_irq_n   (raw),
        .snap_req     (snap),
        .irq_pull_low (pull),
        .irq_status   (stat)
    );

    // Behavioural reference: a delay queue per channel and run-length counters.
    int m_pipe [NCH][$];
    int m_lvl  [NCH];
    int m_run  [NCH];
    int m_pull;
    int m_stat [NCH];

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_pipe[i] = {1, 1};
            m_lvl[i]  = 1;
            m_run[i]  = 0;
            m_stat[i] = 0;
        end
        m_pull = 0;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int any_low;
            any_low = 0;
            for (int i = 0; i < NCH; i++) if (m_lvl[i] == 0) any_low = 1;
            m_pull = any_low;
            if (snap) for (int i = 0; i < NCH; i++) m_stat[i] = (m_lvl[i] == 0) ? 1 : 0;
            for (int i = 0; i < NCH; i++) begin
                int seen;
                seen = m_pipe[i][0];
                if (seen == m_lvl[i]) begin
                    m_run[i] = 0;
                end else begin
                    m_run[i]++;
                    if (m_run[i] >= ((m_lvl[i] == 1) ? LREJ : HREJ)) begin
                        m_lvl[i] = seen;
                        m_run[i] = 0;
                    end
                end
                void'(m_pipe[i].pop_front());
                m_pipe[i].push_back(int'(raw[i]));
            end
        end
    end

    function automatic logic [NCH-1:0] model_stat();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = (m_stat[i] != 0);
        return v;
    endfunction

    // Every-cycle comparison against the reference (R1..R6 via the model).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (pull !== (m_pull != 0)) begin
                fails++;
                $display("FAIL R1 pull-low mismatch at %0t: actual %0b expected %0b", $time, pull, m_pull);
            end
            checks++;
            if (stat !== model_stat()) begin
                fails++;
                $display("FAIL R6 status mismatch at %0t: actual %b expected %b", $time, stat, model_stat());
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_snap(input logic [NCH-1:0] exp, input string req);
        snap = 1'b1;
        cyc(1);
        snap = 1'b0;
        check(stat === exp, req, 8'(stat), 8'(exp));
    endtask

    initial begin
        bit saw;
        @(negedge clk);
        check(pull === 1'b0 && stat === '0, "R7 during reset", {3'b0, pull, stat}, 8'h00);
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check(pull === 1'b0 && stat === '0, "R7 after release", {3'b0, pull, stat}, 8'h00);

        // R5 fall latency, channel 0
        raw[0] = 1'b0;
        cyc(LREJ + 2);
        check(pull === 1'b0, "R5 not yet at edge LREJ+2", 8'(pull), 8'h0);
        cyc(1);
        check(pull === 1'b1, "R5 raised at edge LREJ+3", 8'(pull), 8'h1);
        do_snap(4'b0001, "R6 capture ch0 (register bit 4)");

        // status holds without capture
        raw[2] = 1'b0;
        cyc(40);
        check(stat === 4'b0001, "R6 hold without capture", 8'(stat), 8'h1);
        do_snap(4'b0101, "R6 capture ch0 and ch2");

        // R1: release one of two, pull must stay
        raw[0] = 1'b1;
        cyc(HREJ + 10);
        check(pull === 1'b1, "R1 still low on ch2", 8'(pull), 8'h1);
        raw[2] = 1'b1;
        cyc(HREJ + 2);
        check(pull === 1'b1, "R5 not released at edge HREJ+2", 8'(pull), 8'h1);
        cyc(1);
        check(pull === 1'b0, "R5 released at edge HREJ+3", 8'(pull), 8'h0);
        do_snap(4'b0000, "R2 nothing held after release");

        // R3: low pulse one cycle short
        raw[1] = 1'b0;
        cyc(LREJ - 1);
        raw[1] = 1'b1;
        saw = 1'b0;
        for (int k = 0; k < 30; k++) begin cyc(1); if (pull) saw = 1'b1; end
        check(!saw, "R3 short low pulse rejected", 8'(saw), 8'h0);
        do_snap(4'b0000, "R3 short pulse absent in status");

        // R3: low pulse exactly at threshold
        raw[1] = 1'b0;
        cyc(LREJ);
        raw[1] = 1'b1;
        saw = 1'b0;
        for (int k = 0; k < 30; k++) begin cyc(1); if (pull) saw = 1'b1; end
        check(saw, "R3 threshold pulse accepted", 8'(saw), 8'h1);
        check(pull === 1'b0, "R2 cleared after pulse", 8'(pull), 8'h0);

        // R4: short high gap while low
        raw[3] = 1'b0;
        cyc(LREJ + 5);
        raw[3] = 1'b1;
        cyc(HREJ - 1);
        raw[3] = 1'b0;
        saw = 1'b0;
        for (int k = 0; k < 30; k++) begin cyc(1); if (!pull) saw = 1'b1; end
        check(!saw, "R4 short high gap ignored", 8'(saw), 8'h0);
        do_snap(4'b1000, "R4 ch3 still pending (register bit 7)");

        // R7: reset in the middle of activity
        rst_n = 1'b0;
        cyc(1);
        check(pull === 1'b0 && stat === '0, "R7 mid-run reset", {3'b0, pull, stat}, 8'h00);
        raw = '1;
        cyc(3);
        rst_n = 1'b1;
        cyc(HREJ + 10);

        // Random traffic, compared by the model every cycle
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < NCH; i++) if ($urandom_range(0, 7) == 0) raw[i] = ~raw[i];
            snap = ($urandom_range(0, 5) == 0);
            cyc(1);
        end
        snap = 1'b0;
        raw = '1;
        cyc(LREJ + HREJ + 10);
        check(pull === 1'b0, "R2 idle after random traffic", 8'(pull), 8'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule